// File: doc/BRIEF.md
# TDM Frame Sync Timing Generator

This block produces the frame and timeslot timing for a time-division-multiplexed serial highway that carries 8-bit channels. Each frame has two half-frames, and each half-frame holds between one and thirty-two timeslots. The timeslot count is programmed as the count minus one. The block tracks the current half-frame, timeslot and bit position. It also gives the serial data path a single-cycle strobe that marks where a bit is shifted or sampled. In double-clock mode two bit clocks make up one data bit period.

When the sync pin is an output, the block drives a frame-sync pulse. The pulse width is 1 bit, 2 bits, one byte or half a frame, and it is counted in data bit periods. The edge select places the pulse at the start of the frame or makes it end exactly where the frame ends. When the sync pin is an input, the block synchronises the external sync and restarts its counters on the selected edge. The polarity setting applies in both directions. While the enable is low, every counter is held at zero and the sync output is inactive.

Top module: `tdm_frame_timer`

## Requirements
- R1: During reset, all position outputs are zero, `bit_stb` and `frame_start` are low, and `sync_out` sits at its inactive level.
- R2: `bit_idx` counts 0 to 7 within each timeslot. `slot_idx` advances after bit 7 and wraps to 0 after the slot equal to `chan_m1`, which gives `chan_m1`+1 slots per half-frame. `half_sel` toggles on each wrap, so a frame is two half-frames.
- R3: With `dbl_clk` low, `bit_stb` is high in every enabled cycle. With `dbl_clk` high, it is high only in the second clock of each bit period. The counters move only on a cycle where `bit_stb` is high.
- R4: While `en` is low, the counters are forced to zero from the next clock onward, `bit_stb` and `frame_start` stay low, and `sync_out` is inactive.
- R5: `sync_oe` equals `sync_is_out`. With `sync_is_out` low, `sync_out` stays at its inactive level.
- R6: In master mode the pulse width code sets the active span in data bit periods: 00 gives 1, 01 gives 2, 10 gives 8 and 11 gives a half-frame.
- R7: In master mode with `sync_edge` = 0, the pulse starts at bit 0 of slot 0 in half 0. With `sync_edge` = 1, the pulse occupies the final bit periods of half 1 and ends where the frame ends. The pulse is inactive in the first clock after enable.
- R8: With `sync_pol` = 1 the sync is active high, and with 0 it is active low. This holds for the driven output and for the received input.
- R9: In slave mode `sync_in` passes through two synchroniser flops. `sync_edge` = 0 selects the change into the active level as frame start, and 1 selects the change out of it. On the selected change, the counters read zero after the third rising clock edge. After the second edge, `bit_stb` is low for that one cycle. The other change has no effect.
- R10: `frame_start` is high exactly in the first clock of each frame, that is the first clock of bit 0, slot 0, half 0.
- R11: If `chan_m1` is lowered below the current slot, the counter wraps at the next slot boundary and `half_sel` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| dbl_clk | input | 1 | Two clocks per data bit when high |
| chan_m1 | input | 5 | Timeslots per half-frame minus one |
| sync_is_out | input | 1 | 1: sync driven (master), 0: sync received (slave) |
| width_code | input | 2 | Master pulse width code |
| sync_pol | input | 1 | 1: active-high sync, 0: active-low |
| sync_edge | input | 1 | Frame start edge / pulse placement select |
| sync_in | input | 1 | External frame sync (slave) |
| sync_out | output | 1 | Generated frame sync (master) |
| sync_oe | output | 1 | Output enable for the sync pin |
| half_sel | output | 1 | Current half-frame |
| slot_idx | output | 5 | Current timeslot |
| bit_idx | output | 3 | Current bit within the slot |
| bit_stb | output | 1 | Single-cycle shift/sample strobe |
| frame_start | output | 1 | First clock of a frame |

## Verification
The bench builds the block with its default parameters: 8-bit slots, 32 slots at most and two synchroniser stages. It then varies the slot count at run time over 1, 2, 3, 4, 6 and 32 slots. A single-slot half-frame makes the byte-wide and half-frame-wide pulses span the same bits, and a 16-bit frame brings the trailing two-bit pulse next to the frame wrap. Thirty-two slots drive the 5-bit slot counter across its whole range. Lowering the slot count mid-run exercises the wrap of an out-of-range slot, and slave runs in both clock modes cover the restart from each edge at each polarity.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;

    // Master sync pulse width selection, measured in data bit periods.
    typedef enum logic [1:0] {
        SW_ONE_BIT  = 2'b00,
        SW_TWO_BIT  = 2'b01,
        SW_ONE_SLOT = 2'b10,
        SW_HALF     = 2'b11
    } sync_width_e;

    // Placement of the master pulse relative to the frame boundary.
    typedef enum logic {
        PLACE_LEAD  = 1'b0,
        PLACE_TRAIL = 1'b1
    } sync_place_e;

endpackage

// File: rtl/tdm_sync_detect.sv
module tdm_sync_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slave,
    input  logic sync_pol,
    input  logic edge_sel,
    input  logic sync_in,
    output logic restart
);

    localparam int LAST = (STAGES < 2) ? 1 : STAGES - 1;
    localparam int DEPTH = LAST + 1;

    typedef struct packed {
        logic [DEPTH-1:0] chain;
        logic             lvl;
    } det_t;

    det_t det_d, det_q;
    logic norm;

    always_comb begin
        det_d       = det_q;
        det_d.chain = {det_q.chain[DEPTH-2:0], sync_in};
        // Normalise so that 1 always means the active level.
        norm        = sync_pol ? det_q.chain[LAST] : ~det_q.chain[LAST];
        det_d.lvl   = norm;
        if (edge_sel) begin
            restart = en & slave & det_q.lvl & ~norm;
        end else begin
            restart = en & slave & ~det_q.lvl & norm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/tdm_bit_pacer.sv
module tdm_bit_pacer (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dbl_clk,
    input  logic restart,
    output logic bit_stb,
    output logic phase
);

    typedef struct packed {
        logic ph;
    } pace_t;

    pace_t pace_d, pace_q;

    always_comb begin
        pace_d = pace_q;
        if (!en || restart) begin
            pace_d.ph = 1'b0;
        end else if (dbl_clk) begin
            pace_d.ph = ~pace_q.ph;
        end else begin
            pace_d.ph = 1'b0;
        end
        bit_stb = en & ~restart & (~dbl_clk | pace_q.ph);
        phase   = pace_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pace_q <= '0;
        end else begin
            pace_q <= pace_d;
        end
    end

endmodule

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter #(
    parameter int SLOT_BITS = 8,
    parameter int MAX_SLOTS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         restart,
    input  logic                         bit_stb,
    input  logic [$clog2(MAX_SLOTS)-1:0] chan_m1,
    output logic                         cur_half,
    output logic [$clog2(MAX_SLOTS)-1:0] cur_slot,
    output logic [$clog2(SLOT_BITS)-1:0] cur_bit,
    output logic                         nxt_half,
    output logic [$clog2(MAX_SLOTS)-1:0] nxt_slot,
    output logic [$clog2(SLOT_BITS)-1:0] nxt_bit
);

    localparam int BIT_W  = $clog2(SLOT_BITS);
    localparam int SLOT_W = $clog2(MAX_SLOTS);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(SLOT_BITS - 1);
    localparam logic [BIT_W-1:0]  BIT_ONE  = BIT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);

    typedef struct packed {
        logic              half;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bpos;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (!en || restart) begin
            pos_d = '0;
        end else if (bit_stb) begin
            if (pos_q.bpos == LAST_BIT) begin
                pos_d.bpos = '0;
                // >= also catches a slot left beyond a lowered count.
                if (pos_q.slot >= chan_m1) begin
                    pos_d.slot = '0;
                    pos_d.half = ~pos_q.half;
                end else begin
                    pos_d.slot = pos_q.slot + SLOT_ONE;
                end
            end else begin
                pos_d.bpos = pos_q.bpos + BIT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign cur_half = pos_q.half;
    assign cur_slot = pos_q.slot;
    assign cur_bit  = pos_q.bpos;
    assign nxt_half = pos_d.half;
    assign nxt_slot = pos_d.slot;
    assign nxt_bit  = pos_d.bpos;

endmodule

// File: rtl/tdm_sync_drive.sv
module tdm_sync_drive
    import tdm_frame_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int MAX_SLOTS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         master,
    input  logic [1:0]                   width_code,
    input  logic                         edge_sel,
    input  logic                         sync_pol,
    input  logic [$clog2(MAX_SLOTS)-1:0] chan_m1,
    input  logic                         nxt_half,
    input  logic [$clog2(MAX_SLOTS)-1:0] nxt_slot,
    input  logic [$clog2(SLOT_BITS)-1:0] nxt_bit,
    output logic                         sync_out
);

    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);
    localparam logic [BIT_W-1:0] PEN_BIT  = BIT_W'(SLOT_BITS - 2);
    localparam logic [BIT_W-1:0] ONE_BIT  = BIT_W'(1);

    typedef struct packed {
        logic act;
    } drv_t;

    drv_t        drv_d, drv_q;
    sync_width_e wsel;
    sync_place_e place;
    logic        in_lead;
    logic        in_trail;
    logic        first_slot;
    logic        final_slot;

    always_comb begin
        drv_d      = drv_q;
        wsel       = sync_width_e'(width_code);
        place      = sync_place_e'(edge_sel);
        first_slot = ~nxt_half & (nxt_slot == '0);
        final_slot = nxt_half & (nxt_slot == chan_m1);
        case (wsel)
            SW_ONE_BIT: begin
                in_lead  = first_slot & (nxt_bit == '0);
                in_trail = final_slot & (nxt_bit == LAST_BIT);
            end
            SW_TWO_BIT: begin
                in_lead  = first_slot & (nxt_bit <= ONE_BIT);
                in_trail = final_slot & (nxt_bit >= PEN_BIT);
            end
            SW_ONE_SLOT: begin
                in_lead  = first_slot;
                in_trail = final_slot;
            end
            default: begin
                in_lead  = ~nxt_half;
                in_trail = nxt_half;
            end
        endcase
        // The window is decoded on the next position so the flop lines up with it.
        drv_d.act = en & master & ((place == PLACE_TRAIL) ? in_trail : in_lead);
        sync_out  = drv_q.act ? sync_pol : ~sync_pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int SLOT_BITS   = 8,
    parameter int MAX_SLOTS   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         dbl_clk,
    input  logic [$clog2(MAX_SLOTS)-1:0] chan_m1,
    input  logic                         sync_is_out,
    input  logic [1:0]                   width_code,
    input  logic                         sync_pol,
    input  logic                         sync_edge,
    input  logic                         sync_in,
    output logic                         sync_out,
    output logic                         sync_oe,
    output logic                         half_sel,
    output logic [$clog2(MAX_SLOTS)-1:0] slot_idx,
    output logic [$clog2(SLOT_BITS)-1:0] bit_idx,
    output logic                         bit_stb,
    output logic                         frame_start
);

    localparam int BIT_W  = $clog2(SLOT_BITS);
    localparam int SLOT_W = $clog2(MAX_SLOTS);

    logic              restart_w;
    logic              phase_w;
    logic              nxt_half_w;
    logic [SLOT_W-1:0] nxt_slot_w;
    logic [BIT_W-1:0]  nxt_bit_w;

    tdm_sync_detect #(
        .STAGES (SYNC_STAGES)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .slave    (~sync_is_out),
        .sync_pol (sync_pol),
        .edge_sel (sync_edge),
        .sync_in  (sync_in),
        .restart  (restart_w)
    );

    tdm_bit_pacer u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .dbl_clk (dbl_clk),
        .restart (restart_w),
        .bit_stb (bit_stb),
        .phase   (phase_w)
    );

    tdm_pos_counter #(
        .SLOT_BITS (SLOT_BITS),
        .MAX_SLOTS (MAX_SLOTS)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .restart  (restart_w),
        .bit_stb  (bit_stb),
        .chan_m1  (chan_m1),
        .cur_half (half_sel),
        .cur_slot (slot_idx),
        .cur_bit  (bit_idx),
        .nxt_half (nxt_half_w),
        .nxt_slot (nxt_slot_w),
        .nxt_bit  (nxt_bit_w)
    );

    tdm_sync_drive #(
        .SLOT_BITS (SLOT_BITS),
        .MAX_SLOTS (MAX_SLOTS)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .master     (sync_is_out),
        .width_code (width_code),
        .edge_sel   (sync_edge),
        .sync_pol   (sync_pol),
        .chan_m1    (chan_m1),
        .nxt_half   (nxt_half_w),
        .nxt_slot   (nxt_slot_w),
        .nxt_bit    (nxt_bit_w),
        .sync_out   (sync_out)
    );

    assign sync_oe     = sync_is_out;
    assign frame_start = en & ~phase_w & ~half_sel & (slot_idx == '0) & (bit_idx == '0);

endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
    parameter int SLOT_BITS = 8,
    parameter int MAX_SLOTS = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         en,
    input logic                         dbl_clk,
    input logic [$clog2(MAX_SLOTS)-1:0] chan_m1,
    input logic                         sync_is_out,
    input logic                         sync_pol,
    input logic                         sync_edge,
    input logic                         sync_out,
    input logic                         half_sel,
    input logic [$clog2(MAX_SLOTS)-1:0] slot_idx,
    input logic [$clog2(SLOT_BITS)-1:0] bit_idx,
    input logic                         bit_stb,
    input logic                         restart_w
);

    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (bit_idx == '0 && slot_idx == '0 && !half_sel));

    a_r3_double_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dbl_clk && bit_stb) |=> (!bit_stb || !dbl_clk));

    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_stb && !restart_w) |=>
            ($stable(bit_idx) && $stable(slot_idx) && $stable(half_sel)));

    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_stb && !restart_w && bit_idx != LAST_BIT) |=>
            (bit_idx == $past(bit_idx) + BIT_W'(1)));

    a_r11_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_stb && !restart_w && bit_idx == LAST_BIT && slot_idx >= chan_m1) |=>
            (slot_idx == '0 && half_sel != $past(half_sel)));

    a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart_w |=> (bit_idx == '0 && slot_idx == '0 && !half_sel));

    a_r5_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_is_out ##1 $stable(sync_pol) |-> (sync_out != sync_pol));

    a_r7_lead_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_is_out && $past(sync_is_out) && !sync_edge && !$past(sync_edge) &&
         sync_out == sync_pol) |-> !half_sel);

endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(
    .SLOT_BITS (SLOT_BITS),
    .MAX_SLOTS (MAX_SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .dbl_clk     (dbl_clk),
    .chan_m1     (chan_m1),
    .sync_is_out (sync_is_out),
    .sync_pol    (sync_pol),
    .sync_edge   (sync_edge),
    .sync_out    (sync_out),
    .half_sel    (half_sel),
    .slot_idx    (slot_idx),
    .bit_idx     (bit_idx),
    .bit_stb     (bit_stb),
    .restart_w   (restart_w)
);

// File: tb/test_tdm_frame_timer.sv
`timescale 1ns/1ps
module test_tdm_frame_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       dbl_clk;
    logic [4:0] chan_m1;
    logic       sync_is_out;
    logic [1:0] width_code;
    logic       sync_pol;
    logic       sync_edge;
    logic       sync_in;
    logic       sync_out;
    logic       sync_oe;
    logic       half_sel;
    logic [4:0] slot_idx;
    logic [2:0] bit_idx;
    logic       bit_stb;
    logic       frame_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tdm_frame_timer i_tdm_frame_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .dbl_clk     (dbl_clk),
        .chan_m1     (chan_m1),
        .sync_is_out (sync_is_out),
        .width_code  (width_code),
        .sync_pol    (sync_pol),
        .sync_edge   (sync_edge),
        .sync_in     (sync_in),
        .sync_out    (sync_out),
        .sync_oe     (sync_oe),
        .half_sel    (half_sel),
        .slot_idx    (slot_idx),
        .bit_idx     (bit_idx),
        .bit_stb     (bit_stb),
        .frame_start (frame_start)
    );

    function automatic logic [11:0] observed();
        return {half_sel, slot_idx, bit_idx, bit_stb, frame_start, sync_out};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected outputs c clocks after the counters start from zero.
    function automatic logic [11:0] model(int c, bit dbl, int nsl, int wcode,
                                          bit edg, bit pol, bit master, bit act_ok);
        int bits  = dbl ? c / 2 : c;
        int hb    = 8 * nsl;
        int frame = 2 * hb;
        int p     = bits % frame;
        int w;
        bit hf, st, fs, win, act;
        logic [4:0] sl;
        logic [2:0] bt;
        hf  = (p / hb) != 0;
        sl  = 5'((p % hb) / 8);
        bt  = 3'(p % 8);
        st  = dbl ? (c % 2 == 1) : 1'b1;
        fs  = (p == 0) && (!dbl || (c % 2 == 0));
        w   = (wcode == 0) ? 1 : (wcode == 1) ? 2 : (wcode == 2) ? 8 : hb;
        win = edg ? (p >= frame - w) : (p < w);
        act = master && act_ok && win;
        return {hf, sl, bt, st, fs, act ? pol : ~pol};
    endfunction

    task automatic restart_cfg(bit dbl, int chm1, int wcode, bit edg, bit pol, bit master);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        dbl_clk = dbl; chan_m1 = 5'(chm1); width_code = 2'(wcode);
        sync_edge = edg; sync_pol = pol; sync_is_out = master;
        sync_in = ~pol;
        repeat (4) @(negedge clk);
        en = 1'b1;
    endtask

    // R2 R3 R6 R7 R8 R10: free-running master frames.
    task automatic run_master(string req, bit dbl, int chm1, int wcode, bit edg,
                              bit pol, int cycles);
        restart_cfg(dbl, chm1, wcode, edg, pol, 1'b1);
        for (int c = 0; c < cycles; c++) begin
            #1;
            chk(req, 16'(observed()), 16'(model(c, dbl, chm1 + 1, wcode, edg, pol, 1'b1, c > 0)));
            if (c == 0) chk("R5 oe master", 16'(sync_oe), 16'd1);
            @(negedge clk);
        end
    endtask

    // R9 R5: slave restart on the selected edge only.
    task automatic run_slave(bit dbl, int chm1, bit edg, bit pol);
        int t_x  = edg ? 20 : 10;
        int base = t_x + 3;
        logic [11:0] e;
        restart_cfg(dbl, chm1, 0, edg, pol, 1'b0);
        for (int c = 0; c < base + 40; c++) begin
            if (c == 10) sync_in = pol;
            if (c == 20) sync_in = ~pol;
            #1;
            if (c < base) begin
                e = model(c, dbl, chm1 + 1, 0, edg, pol, 1'b0, 1'b0);
                if (c == t_x + 2) e[2] = 1'b0;
            end else begin
                e = model(c - base, dbl, chm1 + 1, 0, edg, pol, 1'b0, 1'b0);
            end
            chk("R9 slave restart", 16'(observed()), 16'(e));
            if (c == 0) chk("R5 oe slave", 16'(sync_oe), 16'd0);
            @(negedge clk);
        end
    endtask

    // R4: dropping enable mid-frame.
    task automatic run_disable();
        restart_cfg(1'b0, 2, 0, 1'b0, 1'b1, 1'b1);
        repeat (30) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            #1;
            chk("R4 disabled", 16'(observed()), 16'({1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0}));
            @(negedge clk);
        end
    endtask

    // R11: lowering the slot count below the current slot.
    task automatic run_shrink();
        restart_cfg(1'b0, 5, 0, 1'b0, 1'b1, 1'b1);
        for (int c = 0; c < 27; c++) begin
            if (c == 20) chan_m1 = 5'd1;
            #1;
            if (c == 20) chk("R11 before shrink", 16'({half_sel, slot_idx, bit_idx}),
                             16'({1'b0, 5'd2, 3'd4}));
            if (c == 24) chk("R11 wrap after shrink", 16'({half_sel, slot_idx, bit_idx}),
                             16'({1'b1, 5'd0, 3'd0}));
            if (c == 26) chk("R11 continue", 16'({half_sel, slot_idx, bit_idx}),
                             16'({1'b1, 5'd0, 3'd2}));
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; dbl_clk = 1'b0; chan_m1 = '0; sync_is_out = 1'b1;
        width_code = '0; sync_pol = 1'b1; sync_edge = 1'b0; sync_in = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset state", 16'(observed()), 16'({1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0}));
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R4 idle after reset", 16'(observed()), 16'({1'b0, 5'd0, 3'd0, 1'b0, 1'b0, 1'b0}));

        run_master("R2 R6 R7 R10 one-bit lead", 1'b0, 2, 0, 1'b0, 1'b1, 100);
        run_master("R3 R6 R7 R8 two-bit trail dbl", 1'b1, 0, 1, 1'b1, 1'b0, 70);
        run_master("R6 R7 byte lead", 1'b0, 1, 2, 1'b0, 1'b1, 70);
        run_master("R6 R7 half trail", 1'b0, 3, 3, 1'b1, 1'b1, 140);
        run_master("R2 R6 R8 half lead 32 slots", 1'b0, 31, 3, 1'b0, 1'b0, 600);
        run_master("R3 R6 byte trail dbl", 1'b1, 1, 2, 1'b1, 1'b1, 140);
        run_disable();
        run_slave(1'b0, 2, 1'b0, 1'b1);
        run_slave(1'b0, 2, 1'b1, 1'b0);
        run_slave(1'b1, 1, 1'b0, 1'b0);
        run_slave(1'b1, 3, 1'b1, 1'b1);
        run_shrink();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule